// File: doc/BRIEF.md
# Memory chip-select address decoder

This block sits between a processor address bus and a small memory system made of several byte-wide RAM devices and one byte-wide ROM. It splits the incoming address into a device-select field and a word offset. For every device it produces a pair of select lines, one active high and one active low. It passes the offset bits on to the devices. It also contains a model of each device's response to its selects and its read and write strobes, including when that device drives the shared read-data path.

The data bus is presented as split lines. `data_in` carries write data toward the devices. `data_out` carries the byte driven by whichever device currently owns the bus. `data_oe` is the explicit tri-state enable that a pad ring would use to turn the bus around. `dev_oe` shows which device is driving.

With the default parameters there are four RAMs of 128 bytes each and one ROM of 512 bytes. They fill a 1 KiB window that repeats across the 16-bit address space. The RAM storage is clocked: writes land on the rising clock edge. Reads, selects and bus enables are combinational in the address and strobes.

Top module: `mem_sel_decoder`

## Requirements
- R1: While `rst_n` is low and after it rises, every RAM byte holds 0, so any RAM read before the first write returns 0.
- R2: RAM device i gets `ram_cs1[i]`=1 exactly when addr[8:7]==i, and `ram_cs2[i]`=addr[9]. A RAM responds only when its cs1=1 and cs2=0. The ROM gets `rom_cs1`=addr[9] and `rom_cs2`=~addr[9]. Bit positions are 0-based.
- R3: addr[9]=0 selects RAM number addr[8:7], and addr[9]=1 selects the ROM. Bits 15:10 are ignored, so the map repeats every 1024 addresses. With the defaults, RAM0..RAM3 cover 0x000-0x07F, 0x080-0x0FF, 0x100-0x17F and 0x180-0x1FF, and the ROM covers 0x200-0x3FF.
- R4: A selected RAM with rd=0 and wr=0 neither drives the bus nor changes its contents.
- R5: A selected RAM with rd=1 and wr=0 drives its stored byte at offset addr[6:0] onto `data_out`, in the same cycle, with `data_oe`=1.
- R6: A selected RAM with wr=1 stores `data_in` at offset addr[6:0] on the next rising clock edge, whatever rd is, and does not drive the bus.
- R7: `ram_addr` always equals addr[6:0] and `rom_addr` always equals addr[8:0].
- R8: With the ROM selected and rd=1, `data_out` is the ROM byte at word w=addr[8:0], which is ((w*37+11) XOR (w>>1)) mod 256, with `data_oe`=1.
- R9: The ROM ignores wr. With the ROM selected, wr=1 and rd=0, nothing drives the bus. wr=1 with rd=1 still reads, and ROM contents never change.
- R10: `dev_oe` (bits 0..3 for RAM0..RAM3, bit 4 for the ROM) has at most one bit set. `data_oe` is the OR of those bits, and `data_out` is 0 whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM writes |
| rst_n | input | 1 | Active-low reset, clears RAM contents |
| addr | input | 16 | Processor address |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high, takes priority over rd at RAMs |
| data_in | input | 8 | Write data toward the devices |
| ram_cs1 | output | 4 | Active-high select per RAM |
| ram_cs2 | output | 4 | Active-low select per RAM |
| rom_cs1 | output | 1 | Active-high ROM select |
| rom_cs2 | output | 1 | Active-low ROM select |
| ram_addr | output | 7 | Offset forwarded to RAMs |
| rom_addr | output | 9 | Offset forwarded to the ROM |
| dev_oe | output | 5 | Per-device bus-drive enable (RAM0..3, ROM) |
| data_oe | output | 1 | Tri-state enable of the shared data bus |
| data_out | output | 8 | Byte driven onto the data bus |

## Verification
Random addresses are used with random high bits and all four rd/wr combinations. This separates a decoder that looks at the wrong bits, or leaks the ignored upper bits, from a correct one, and it separates write-wins from read-wins at the RAMs. Directed accesses hit the edges of each region (0x07F/0x080, 0x1FF/0x200, 0x3FF/0x400) and catch off-by-one boundary decoding. A write through an alias such as 0x0400, read back at 0x0000, shows the map repeats rather than fanning out to a phantom device. Writes to the ROM, and idle cycles at a RAM followed by read-back, show that those cycles leave both the bus and the stored bytes untouched.

// File: rtl/mem_sel_pkg.sv
package mem_sel_pkg;

   // kind of access a RAM device sees once its selects are evaluated
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   // constant ROM image, computed rather than tabulated
   function automatic logic [31:0] rom_pattern(input logic [31:0] w);
      return (w * 32'd37 + 32'd11) ^ (w >> 1);
   endfunction

   // strobe resolution at a RAM: write wins over read
   function automatic acc_e resolve_access(input logic enabled,
                                           input logic rd,
                                           input logic wr);
      if (!enabled)  return ACC_IDLE;
      if (wr)        return ACC_WRITE;
      if (rd)        return ACC_READ;
      return ACC_IDLE;
   endfunction

endpackage

// File: rtl/chip_decoder.sv
module chip_decoder #(
   parameter int RAM_AW = 7,
   parameter int N_RAM  = 4,
   localparam int SEL_W  = $clog2(N_RAM),
   localparam int ROM_AW = RAM_AW + SEL_W
) (
   input  logic [ROM_AW:0]     win_addr,
   output logic [N_RAM-1:0]    ram_cs1,
   output logic [N_RAM-1:0]    ram_cs2,
   output logic                rom_cs1,
   output logic                rom_cs2,
   output logic [RAM_AW-1:0]   ram_addr,
   output logic [ROM_AW-1:0]   rom_addr
);

   localparam int MAP_BIT = ROM_AW;

   logic             map_rom;
   logic [SEL_W-1:0] bank_sel;

   assign map_rom  = win_addr[MAP_BIT];
   assign bank_sel = win_addr[ROM_AW-1:RAM_AW];
   assign ram_addr = win_addr[RAM_AW-1:0];
   assign rom_addr = win_addr[ROM_AW-1:0];

   // 2-to-N decoder drives the active-high select, region bit the active-low one
   for (genvar i = 0; i < N_RAM; i++) begin : g_ram_sel
      assign ram_cs1[i] = (bank_sel == SEL_W'(i));
      assign ram_cs2[i] = map_rom;
   end

   assign rom_cs1 = map_rom;
   assign rom_cs2 = ~map_rom;

endmodule

// File: rtl/ram_bank.sv
module ram_bank
   import mem_sel_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 8,
   localparam int DEPTH = 2 ** AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs1,
   input  logic          cs2,
   input  logic          rd,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          oe
);

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("ram_bank: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ram_bank: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic          enabled;
   acc_e          acc;

   assign enabled = cs1 & ~cs2;
   assign acc     = resolve_access(enabled, rd, wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (acc == ACC_WRITE) begin
         mem[addr] <= wdata;
      end
   end

   assign oe    = (acc == ACC_READ);
   assign rdata = mem[addr];

   // R2: drive only when selected by cs1=1, cs2=0
   a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (cs1 && !cs2));

   // R6: a write lands at the addressed byte on the next edge
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && wr) |=> (mem[$past(addr)] == $past(wdata)));

   // R6: no bus drive during a write even with rd high
   a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && wr && rd) |-> !oe);

   // R4: an idle selected cycle leaves the addressed byte unchanged
   a_r4_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !rd && !wr) |=> (mem[$past(addr)] == $past(mem[addr])));

endmodule

// File: rtl/rom_block.sv
module rom_block
   import mem_sel_pkg::*;
#(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input  logic          cs1,
   input  logic          cs2,
   input  logic          rd,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] rdata,
   output logic          oe
);

   if (DW > 32) begin : g_bad_dw
      $error("rom_block: DW above 32 not supported by the pattern");
   end

   logic [31:0] word;

   // no write strobe enters the ROM: it answers to rd alone
   assign word  = rom_pattern(32'(addr));
   assign rdata = word[DW-1:0];
   assign oe    = cs1 & ~cs2 & rd;

endmodule

// File: rtl/mem_sel_decoder.sv
module mem_sel_decoder #(
   parameter int ADDR_W = 16,
   parameter int DW     = 8,
   parameter int RAM_AW = 7,
   parameter int N_RAM  = 4,
   localparam int SEL_W  = $clog2(N_RAM),
   localparam int ROM_AW = RAM_AW + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [DW-1:0]     data_in,
   output logic [N_RAM-1:0]  ram_cs1,
   output logic [N_RAM-1:0]  ram_cs2,
   output logic              rom_cs1,
   output logic              rom_cs2,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [ROM_AW-1:0] rom_addr,
   output logic [N_RAM:0]    dev_oe,
   output logic              data_oe,
   output logic [DW-1:0]     data_out
);

   localparam int MAP_BIT = ROM_AW;
   localparam int N_DEV   = N_RAM + 1;

   if (N_RAM < 2 || (N_RAM & (N_RAM - 1)) != 0) begin : g_bad_nram
      $error("mem_sel_decoder: N_RAM must be a power of two of at least 2");
   end
   if (ADDR_W < MAP_BIT + 1) begin : g_bad_aw
      $error("mem_sel_decoder: ADDR_W too narrow for the map");
   end

   // upper address bits are don't-care: the map repeats
   if (ADDR_W > MAP_BIT + 1) begin : g_alias
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[ADDR_W-1:MAP_BIT+1];
   end

   chip_decoder #(.RAM_AW(RAM_AW), .N_RAM(N_RAM)) u_dec (
      .win_addr (addr[MAP_BIT:0]),
      .ram_cs1  (ram_cs1),
      .ram_cs2  (ram_cs2),
      .rom_cs1  (rom_cs1),
      .rom_cs2  (rom_cs2),
      .ram_addr (ram_addr),
      .rom_addr (rom_addr)
   );

   logic [DW-1:0] dev_data [N_DEV];

   for (genvar i = 0; i < N_RAM; i++) begin : g_ram
      ram_bank #(.AW(RAM_AW), .DW(DW)) u_ram (
         .clk   (clk),
         .rst_n (rst_n),
         .cs1   (ram_cs1[i]),
         .cs2   (ram_cs2[i]),
         .rd    (rd),
         .wr    (wr),
         .addr  (ram_addr),
         .wdata (data_in),
         .rdata (dev_data[i]),
         .oe    (dev_oe[i])
      );
   end

   rom_block #(.AW(ROM_AW), .DW(DW)) u_rom (
      .cs1   (rom_cs1),
      .cs2   (rom_cs2),
      .rd    (rd),
      .addr  (rom_addr),
      .rdata (dev_data[N_RAM]),
      .oe    (dev_oe[N_RAM])
   );

   // AND-OR bus merge; enables are exclusive so OR is safe
   always_comb begin
      data_out = '0;
      for (int i = 0; i < N_DEV; i++) begin
         if (dev_oe[i]) data_out = data_out | dev_data[i];
      end
   end

   assign data_oe = |dev_oe;

   logic [N_RAM:0] dev_en;
   for (genvar i = 0; i < N_RAM; i++) begin : g_en
      assign dev_en[i] = ram_cs1[i] & ~ram_cs2[i];
   end
   assign dev_en[N_RAM] = rom_cs1 & ~rom_cs2;

   // R10: never two drivers on the bus
   a_r10_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_oe));

   // R3: every address enables exactly one device
   a_r3_one_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dev_en) == 1);

   // R5: the bus is only driven during a read strobe
   a_r5_drive_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> rd);

   // R9: a pure write into the ROM range leaves the ROM off the bus
   a_r9_rom_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_cs1 && !rom_cs2 && wr && !rd) |-> !dev_oe[N_RAM]);

   // R10: released bus reads as zero
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> (data_out == '0));

endmodule

// File: tb/sim_mem_sel_decoder.sv
module sim_mem_sel_decoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] addr;
   logic        rd, wr;
   logic [7:0]  data_in;
   logic [3:0]  ram_cs1, ram_cs2;
   logic        rom_cs1, rom_cs2;
   logic [6:0]  ram_addr;
   logic [8:0]  rom_addr;
   logic [4:0]  dev_oe;
   logic        data_oe;
   logic [7:0]  data_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [7:0] ref_ram [512];

   always #4 clk = ~clk;

   mem_sel_decoder u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
      .data_in(data_in), .ram_cs1(ram_cs1), .ram_cs2(ram_cs2),
      .rom_cs1(rom_cs1), .rom_cs2(rom_cs2), .ram_addr(ram_addr),
      .rom_addr(rom_addr), .dev_oe(dev_oe), .data_oe(data_oe),
      .data_out(data_out)
   );

   function automatic logic [7:0] rom_ref(input logic [8:0] w);
      int unsigned v;
      v = ((int'(w) * 37 + 11) ^ (int'(w) >> 1)) & 255;
      return v[7:0];
   endfunction

   function automatic logic [4:0] exp_oe(input logic [15:0] a, input logic r, input logic w);
      logic [4:0] e;
      e = '0;
      if (a[9]) e[4] = r;
      else      e[a[8:7]] = r & ~w;
      return e;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle: drive at negedge, check 2 ns later, write lands at posedge
   task automatic op(input logic [15:0] a, input logic r, input logic w,
                     input logic [7:0] d, input string tag);
      logic [4:0] eo;
      logic [7:0] ed;
      logic [3:0] ecs1;
      @(negedge clk);
      addr = a; rd = r; wr = w; data_in = d;
      #2;
      eo = exp_oe(a, r, w);
      ed = 8'h00;
      if (eo[4])       ed = rom_ref(a[8:0]);
      else if (|eo)    ed = ref_ram[a[8:0]];
      ecs1 = 4'b0001 << a[8:7];
      chk(ram_cs1 == ecs1 && ram_cs2 == {4{a[9]}}, "R2 ram selects", {ram_cs1, ram_cs2}, {ecs1, {4{a[9]}}});
      chk(rom_cs1 == a[9] && rom_cs2 == ~a[9], "R2 rom selects", {rom_cs1, rom_cs2}, {a[9], ~a[9]});
      chk(ram_addr == a[6:0] && rom_addr == a[8:0], "R7 offsets", {ram_addr, rom_addr}, {a[6:0], a[8:0]});
      chk(dev_oe == eo, "R10 dev_oe", 32'(dev_oe), 32'(eo));
      chk(data_oe == |eo, "R10 data_oe", 32'(data_oe), 32'(|eo));
      chk(data_out == ed, tag, 32'(data_out), 32'(ed));
      if (!a[9] && w) ref_ram[a[8:0]] = d;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 512; k++) ref_ram[k] = 8'h00;
      rst_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0; data_in = '0;
      repeat (3) @(negedge clk);
      addr = 16'h0105; rd = 1'b1;
      #2;
      chk(data_out == 8'h00 && data_oe, "R1 during reset", {data_oe, data_out}, {1'b1, 8'h00});
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every RAM byte reads zero after reset
      for (int k = 0; k < 512; k++) op(16'(k), 1'b1, 1'b0, 8'h00, "R1 reset contents");

      // R3 boundaries, each written with a distinct byte then read
      op(16'h007F, 1'b0, 1'b1, 8'hA1, "R6 write 007F");
      op(16'h0080, 1'b0, 1'b1, 8'hB2, "R6 write 0080");
      op(16'h01FF, 1'b1, 1'b1, 8'hC3, "R6 write wins over rd");
      op(16'h007F, 1'b1, 1'b0, 8'h00, "R3 read 007F");
      op(16'h0080, 1'b1, 1'b0, 8'h00, "R3 read 0080");
      op(16'h01FF, 1'b1, 1'b0, 8'h00, "R5 read 01FF");
      op(16'h0200, 1'b1, 1'b0, 8'h00, "R8 rom first word");
      op(16'h03FF, 1'b1, 1'b0, 8'h00, "R8 rom last word");

      // R3 aliasing: write through 0x0400 and 0xFC00, read at 0x0000
      op(16'h0400, 1'b0, 1'b1, 8'h5A, "R3 alias write");
      op(16'h0000, 1'b1, 1'b0, 8'h00, "R3 alias read");
      op(16'hFC00, 1'b0, 1'b1, 8'h6B, "R3 high alias write");
      op(16'h0000, 1'b1, 1'b0, 8'h00, "R3 high alias read");
      op(16'hFE00, 1'b1, 1'b0, 8'h00, "R3 rom alias read");

      // R4: idle selected cycle, then read back unchanged
      op(16'h0000, 1'b0, 1'b0, 8'hFF, "R4 idle no drive");
      op(16'h0000, 1'b1, 1'b0, 8'h00, "R4 idle kept byte");

      // R9: ROM ignores writes
      op(16'h0234, 1'b0, 1'b1, 8'h11, "R9 rom write undriven");
      op(16'h0234, 1'b1, 1'b1, 8'h22, "R9 rom read with wr high");
      op(16'h0234, 1'b1, 1'b0, 8'h00, "R9 rom unchanged");
      op(16'h0034, 1'b1, 1'b0, 8'h00, "R9 ram under rom offset untouched");

      // random mix across the whole space and all strobe combinations
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         logic [1:0]  s;
         a = 16'($urandom);
         s = 2'($urandom);
         op(a, s[0], s[1], 8'($urandom), "R5 R6 R8 random access");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule